// File: doc/BRIEF.md
# Flag-Setting Integer ALU

A purely combinational data-processing unit for a 32-bit RISC integer pipeline. It receives a 4-bit operation code, a first operand, a second operand that an upstream shifter has already prepared, the current condition flags, and the carry bit the shifter produced. It returns the operation result, a strobe saying whether that result should be written to the destination register, and the next value of the negative, zero, carry and overflow flags.

Arithmetic forms route through one adder that can invert either operand and take a carry-in of 0, 1 or the incoming carry flag. This covers plain, with-carry and reversed subtraction. Subtraction carry means "no borrow occurred". Logical forms take their carry from the shifter and leave overflow alone. The four compare and test forms only touch the flags. When the set-flags input is low, the flags pass through unchanged.

Top module: `flag_alu`

## Requirements
- R1: ADD (opcode 4) returns A+B. ADC (opcode 5) returns A+B+C_in, with C_in taken from flags_i bit 1. When flags are set, C is the unsigned carry out of bit 31.
- R2: SUB (opcode 2) and CMP (opcode 10) compute A-B. When flags are set, C is 1 exactly when no borrow occurs.
- R3: SBC (opcode 6) returns A-B-(1-C_in). Its carry follows the same no-borrow rule as R2.
- R4: RSB (opcode 3) returns B-A and RSC (opcode 7) returns B-A-(1-C_in). Both use the no-borrow carry.
- R5: For arithmetic forms, V is set when the effective two's-complement addition, taken after any operand inversion, overflows the signed range.
- R6: TST (8), TEQ (9), CMP (10) and CMN (11) drive wr_en_o low. Every other opcode drives it high.
- R7: Logical forms with flags set behave as follows:
  - The opcodes are AND 0, EOR 1, TST 8, TEQ 9, ORR 12, MOV 13, BIC 14 and MVN 15.
  - C is taken from shc_i.
  - V keeps its incoming value.
  - The functions are MOV=B, MVN=~B, BIC=A&~B, and TST/TEQ behave as AND/EOR.
- R8: When set_flags_i is 0, flags_o equals flags_i for every opcode.
- R9: When flags are set, N is bit 31 of the operation value and Z is 1 when that value is zero. This also applies to compare and test forms.
- R10: Flags are packed as {N,Z,C,V} in bits 3..0. All outputs follow the inputs with no clock latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 4 | Operation code |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Pre-shifted second operand |
| flags_i | input | 4 | Current flags {N,Z,C,V} |
| shc_i | input | 1 | Shifter carry-out |
| set_flags_i | input | 1 | Update flags when high |
| res_o | output | 32 | Operation value |
| wr_en_o | output | 1 | Destination write strobe |
| flags_o | output | 4 | Next flags {N,Z,C,V} |

## Verification
Every output is due in the same cycle as its inputs, because no register lies on any path. The bench applies each stimulus just after a falling clock edge and samples one time unit later, well clear of the rising edge. Carry, overflow and zero corners are driven with directed operand pairs. A sweep over all sixteen opcodes checks the write strobe and flag hold-through.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;
  typedef enum logic [3:0] {
    OP_AND = 4'h0, OP_EOR = 4'h1, OP_SUB = 4'h2, OP_RSB = 4'h3,
    OP_ADD = 4'h4, OP_ADC = 4'h5, OP_SBC = 4'h6, OP_RSC = 4'h7,
    OP_TST = 4'h8, OP_TEQ = 4'h9, OP_CMP = 4'hA, OP_CMN = 4'hB,
    OP_ORR = 4'hC, OP_MOV = 4'hD, OP_BIC = 4'hE, OP_MVN = 4'hF
  } alu_op_e;

  typedef enum logic [1:0] {CIN_ZERO, CIN_ONE, CIN_FLAG} cin_sel_e;

  localparam int unsigned FLAG_N = 3;
  localparam int unsigned FLAG_Z = 2;
  localparam int unsigned FLAG_C = 1;
  localparam int unsigned FLAG_V = 0;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             inv_a_i,
  input  logic             inv_b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o,
  output logic             ovf_o
);
  logic [WIDTH-1:0] x, y;
  logic [WIDTH:0]   full;

  assign x      = a_i ^ {WIDTH{inv_a_i}};
  assign y      = b_i ^ {WIDTH{inv_b_i}};
  assign full   = {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, cin_i};
  assign sum_o  = full[WIDTH-1:0];
  assign cout_o = full[WIDTH];
  // signed overflow: like-signed inputs, differently signed sum
  assign ovf_o  = (x[WIDTH-1] == y[WIDTH-1]) && (sum_o[WIDTH-1] != x[WIDTH-1]);
endmodule

// File: rtl/alu_logic.sv
module alu_logic
  import flag_alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [3:0]       op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] res_o
);
  always_comb begin
    unique case (alu_op_e'(op_i))
      OP_AND, OP_TST: res_o = a_i & b_i;
      OP_EOR, OP_TEQ: res_o = a_i ^ b_i;
      OP_ORR:         res_o = a_i | b_i;
      OP_MOV:         res_o = b_i;
      OP_BIC:         res_o = a_i & ~b_i;
      OP_MVN:         res_o = ~b_i;
      default:        res_o = '0;
    endcase
  end
endmodule

// File: rtl/alu_flags.sv
module alu_flags
  import flag_alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] val_i,
  input  logic             arith_i,
  input  logic             add_c_i,
  input  logic             add_v_i,
  input  logic             shc_i,
  input  logic             set_i,
  input  logic [3:0]       flags_i,
  output logic [3:0]       flags_o
);
  logic [3:0] upd;

  always_comb begin
    upd[FLAG_N] = val_i[WIDTH-1];
    upd[FLAG_Z] = ~|val_i;
    upd[FLAG_C] = arith_i ? add_c_i : shc_i;
    upd[FLAG_V] = arith_i ? add_v_i : flags_i[FLAG_V];
    flags_o     = set_i ? upd : flags_i;
  end

  always_comb begin
    p_logic_keep_v_r7: assert (!(set_i && !arith_i) ||
                               (flags_o[FLAG_V] == flags_i[FLAG_V] && flags_o[FLAG_C] == shc_i))
      else $error("logical op altered V or ignored shifter carry");
  end
endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import flag_alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [3:0]       op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [3:0]       flags_i,
  input  logic             shc_i,
  input  logic             set_flags_i,
  output logic [WIDTH-1:0] res_o,
  output logic             wr_en_o,
  output logic [3:0]       flags_o
);
  logic             arith, inv_a, inv_b, cin;
  cin_sel_e         cin_sel;
  logic [WIDTH-1:0] sum, lres, val;
  logic             add_c, add_v;

  // operation decode
  always_comb begin
    arith   = 1'b1;
    inv_a   = 1'b0;
    inv_b   = 1'b0;
    cin_sel = CIN_ZERO;
    wr_en_o = 1'b1;
    unique case (alu_op_e'(op_i))
      OP_ADD:         ;
      OP_CMN:         wr_en_o = 1'b0;
      OP_ADC:         cin_sel = CIN_FLAG;
      OP_SUB:         begin inv_b = 1'b1; cin_sel = CIN_ONE; end
      OP_CMP:         begin inv_b = 1'b1; cin_sel = CIN_ONE; wr_en_o = 1'b0; end
      OP_SBC:         begin inv_b = 1'b1; cin_sel = CIN_FLAG; end
      OP_RSB:         begin inv_a = 1'b1; cin_sel = CIN_ONE; end
      OP_RSC:         begin inv_a = 1'b1; cin_sel = CIN_FLAG; end
      OP_TST, OP_TEQ: begin arith = 1'b0; wr_en_o = 1'b0; end
      default:        arith = 1'b0;
    endcase
  end

  always_comb begin
    unique case (cin_sel)
      CIN_ONE:  cin = 1'b1;
      CIN_FLAG: cin = flags_i[FLAG_C];
      default:  cin = 1'b0;
    endcase
  end

  alu_addsub #(.WIDTH(WIDTH)) u_addsub (
    .a_i(a_i), .b_i(b_i), .inv_a_i(inv_a), .inv_b_i(inv_b), .cin_i(cin),
    .sum_o(sum), .cout_o(add_c), .ovf_o(add_v)
  );

  alu_logic #(.WIDTH(WIDTH)) u_logic (
    .op_i(op_i), .a_i(a_i), .b_i(b_i), .res_o(lres)
  );

  assign val   = arith ? sum : lres;
  assign res_o = val;

  alu_flags #(.WIDTH(WIDTH)) u_flags (
    .val_i(val), .arith_i(arith), .add_c_i(add_c), .add_v_i(add_v),
    .shc_i(shc_i), .set_i(set_flags_i), .flags_i(flags_i), .flags_o(flags_o)
  );

  always_comb begin
    p_no_write_cmp_r6: assert (!wr_en_o || !(op_i inside {OP_TST, OP_TEQ, OP_CMP, OP_CMN}))
      else $error("compare/test form asserted write strobe");
    p_flags_hold_r8: assert (set_flags_i || flags_o == flags_i)
      else $error("flags changed with set-flags low");
    p_zero_flag_r9: assert (!set_flags_i || flags_o[FLAG_Z] == (res_o == '0))
      else $error("Z disagrees with result");
    p_neg_flag_r9: assert (!set_flags_i || flags_o[FLAG_N] == res_o[WIDTH-1])
      else $error("N disagrees with result");
  end
endmodule

// File: tb/flag_alu_bench.sv
module flag_alu_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  op;
  logic [31:0] a, b;
  logic [3:0]  fin;
  logic        shc, setf;
  logic [31:0] res;
  logic        wr;
  logic [3:0]  fout;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flag_alu u_flag_alu (
    .op_i(op), .a_i(a), .b_i(b), .flags_i(fin), .shc_i(shc),
    .set_flags_i(setf), .res_o(res), .wr_en_o(wr), .flags_o(fout)
  );

  task automatic apply(input logic [3:0] o, input logic [31:0] av, input logic [31:0] bv,
                       input logic [3:0] f, input logic sc, input logic s);
    @(negedge clk);
    op = o; a = av; b = bv; fin = f; shc = sc; setf = s;
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] er, input logic ew,
                       input logic [3:0] ef, input bit chk_res);
    checks++;
    if ((chk_res && res !== er) || wr !== ew || fout !== ef) begin
      fails++;
      $display("FAIL %s: res=%h wr=%b flags=%b expected res=%h wr=%b flags=%b",
               req, res, wr, fout, er, ew, ef);
    end
  endtask

  task automatic t_reset_state();
    apply(4'h4, 32'h0, 32'h0, 4'b0000, 1'b0, 1'b0);
    check("R10 idle", 32'h0, 1'b1, 4'b0000, 1);
  endtask

  task automatic t_add();
    apply(4'h4, 32'h8000_0000, 32'h8000_0000, 4'b0000, 1'b0, 1'b1);
    check("R1 R5 R9 add wrap", 32'h0, 1'b1, 4'b0111, 1);
    apply(4'h4, 32'hBAAD_0000, 32'h0000_CAFE, 4'b1111, 1'b0, 1'b0);
    check("R8 add no set", 32'hBAAD_CAFE, 1'b1, 4'b1111, 1);
    apply(4'h5, 32'd1, 32'd2, 4'b0000, 1'b0, 1'b1);
    check("R1 adc c0", 32'd3, 1'b1, 4'b0000, 1);
    apply(4'h5, 32'd1, 32'd2, 4'b0010, 1'b0, 1'b1);
    check("R1 adc c1", 32'd4, 1'b1, 4'b0000, 1);
  endtask

  task automatic t_sub();
    apply(4'h2, 32'hBAAD_CAFE, 32'h0000_CAFE, 4'b0000, 1'b0, 1'b1);
    check("R2 sub no borrow", 32'hBAAD_0000, 1'b1, 4'b1010, 1);
    apply(4'h2, 32'h8000_0000, 32'd1, 4'b0000, 1'b0, 1'b1);
    check("R5 sub overflow", 32'h7FFF_FFFF, 1'b1, 4'b0011, 1);
    apply(4'h2, 32'd0, 32'd1, 4'b0010, 1'b0, 1'b1);
    check("R2 sub borrow", 32'hFFFF_FFFF, 1'b1, 4'b1000, 1);
  endtask

  task automatic t_sbc();
    apply(4'h6, 32'd0, 32'd0, 4'b0000, 1'b0, 1'b1);
    check("R3 sbc c0", 32'hFFFF_FFFF, 1'b1, 4'b1000, 1);
    apply(4'h6, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'b0010, 1'b0, 1'b1);
    check("R3 sbc c1", 32'h0, 1'b1, 4'b0110, 1);
  endtask

  task automatic t_reverse();
    apply(4'h3, 32'd1, 32'd2, 4'b0000, 1'b0, 1'b1);
    check("R4 rsb", 32'd1, 1'b1, 4'b0010, 1);
    apply(4'h7, 32'd1, 32'd2, 4'b0000, 1'b0, 1'b1);
    check("R4 rsc c0", 32'd0, 1'b1, 4'b0110, 1);
    apply(4'h7, 32'd1, 32'd2, 4'b0010, 1'b0, 1'b1);
    check("R4 rsc c1", 32'd1, 1'b1, 4'b0010, 1);
  endtask

  task automatic t_compare();
    apply(4'hA, 32'd16, 32'd16, 4'b0000, 1'b0, 1'b1);
    check("R6 R9 cmp equal", 32'h0, 1'b0, 4'b0110, 0);
    apply(4'hA, 32'd2, 32'd1, 4'b0000, 1'b0, 1'b1);
    check("R2 cmp greater", 32'h0, 1'b0, 4'b0010, 0);
    apply(4'hB, 32'hFFFF_FFFF, 32'd1, 4'b0000, 1'b0, 1'b1);
    check("R6 cmn", 32'h0, 1'b0, 4'b0110, 0);
  endtask

  task automatic t_logic();
    apply(4'h9, 32'd1, 32'd1, 4'b0011, 1'b1, 1'b1);
    check("R7 teq keeps V", 32'h0, 1'b0, 4'b0111, 0);
    apply(4'h8, 32'd1, 32'd2, 4'b0000, 1'b0, 1'b1);
    check("R7 tst zero", 32'h0, 1'b0, 4'b0100, 0);
    apply(4'hC, 32'd1, 32'h9111_1110, 4'b0000, 1'b1, 1'b1);
    check("R7 orr", 32'h9111_1111, 1'b1, 4'b1010, 1);
    apply(4'hD, 32'h1234_5678, 32'h8000_0000, 4'b0001, 1'b1, 1'b1);
    check("R7 mov V kept", 32'h8000_0000, 1'b1, 4'b1011, 1);
    apply(4'hF, 32'h0, 32'h0, 4'b0010, 1'b0, 1'b1);
    check("R7 mvn C from shifter", 32'hFFFF_FFFF, 1'b1, 4'b1000, 1);
    apply(4'hE, 32'h0000_FFFF, 32'h0000_00FF, 4'b0000, 1'b0, 1'b0);
    check("R7 bic", 32'h0000_FF00, 1'b1, 4'b0000, 1);
    apply(4'h0, 32'h0000_FF0F, 32'h0000_F0F0, 4'b0000, 1'b0, 1'b0);
    check("R7 and", 32'h0000_F000, 1'b1, 4'b0000, 1);
    apply(4'h1, 32'hFFFF_0000, 32'hF0F0_F0F0, 4'b0000, 1'b0, 1'b0);
    check("R7 eor", 32'h0F0F_F0F0, 1'b1, 4'b0000, 1);
  endtask

  task automatic t_sweep();
    for (int o = 0; o < 16; o++) begin
      apply(o[3:0], 32'h5A5A_1234, 32'h0F0F_8765, 4'b1001, 1'b1, 1'b0);
      check("R6 R8 R10 sweep", 32'h0, !(o >= 8 && o <= 11), 4'b1001, 0);
    end
  endtask

  initial begin
    op = '0; a = '0; b = '0; fin = '0; shc = 1'b0; setf = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_add();
    t_sub();
    t_sbc();
    t_reverse();
    t_compare();
    t_logic();
    t_sweep();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule